// File: doc/BRIEF.md
# Aperture Remap Translation Cache

This block caches translations from graphics aperture pages to physical pages. A requester presents a byte address inside the aperture together with a code naming its class (host processor, graphics port or PCI). One cycle after the block accepts the lookup it answers. The answer is either a hit carrying the physical address or a miss. Pages are 4 KB, so the low 12 address bits are copied unchanged onto the physical address.

On a miss the block fetches the missing table entry through a simple read port. It raises a request carrying the aperture page number and waits for an acknowledge that carries the physical page number. Only one fetch runs at a time, and the block refuses new lookups until that fetch ends. The requester then repeats its lookup, which now hits. The cache holds 16 entries and is fully associative. When every entry is valid, the fill replaces the least recently used entry.

Each requester class has its own translation enable. A class whose enable is off has its addresses passed straight through, and that lookup leaves the cache contents and the replacement order alone. A flush input invalidates every entry in one cycle.

Top module: `aperture_remap_tlb`

## Requirements
- R1: After reset `req_ready` is 1, `walk_req` is 0 and `rsp_valid` is 0. Every entry is invalid, so the first translated lookup misses.
- R2: A lookup is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `rsp_valid` is 1 in exactly the following cycle. On a translated hit, `rsp_hit` is 1 and `rsp_paddr` is {cached physical page, `req_vaddr[11:0]`}.
- R3: On a translated miss, `rsp_hit` is 0. From the next cycle `walk_req` is 1 and `walk_vpn` equals `req_vaddr[31:12]`. Both hold steady until the cycle in which `walk_ack` is 1.
- R4: On the edge where `walk_ack` is 1, the page is written into an entry with physical page `walk_ppn`. A later lookup of that page by any requester class whose translation is enabled then hits. No page ever sits in two entries.
- R5: From the cycle after a miss is accepted until the edge that samples `walk_ack`, `req_ready` is 0 and no lookup is accepted. `req_ready` is 1 again in the cycle after that edge.
- R6: Class codes are 0 for host, 1 for graphics port and 2 for PCI. `xlate_en[c]` enables translation for class code c, and code 3 is never translated. An untranslated lookup answers with `rsp_hit` = 1 and `rsp_paddr` = `req_vaddr`, and it starts no fetch.
- R7: An untranslated lookup does not change which entry is least recently used.
- R8: A fill goes to the lowest-numbered invalid entry if one exists. Otherwise it goes to the least recently used entry. A translated hit and a fill each make their entry the most recently used. A miss leaves the order unchanged.
- R9: While `flush` is 1, `req_ready` is 0. After the edge that samples `flush`, every entry is invalid.
- R10: If `flush` is 1 at any edge while a fetch is outstanding, including the acknowledge edge, the fetched entry is discarded and not written.
- R11: All 16 entries are usable at once, so 16 distinct pages can be resident together and all of them hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| xlate_en | input | 3 | Translation enable for each class code 0..2 |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup |
| req_class | input | 2 | Requester class code |
| req_vaddr | input | 32 | Aperture byte address |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | 1: translation or pass-through, 0: miss |
| rsp_paddr | output | 32 | Physical byte address (0 on a miss) |
| walk_req | output | 1 | Table fetch outstanding |
| walk_vpn | output | 20 | Aperture page number to fetch |
| walk_ack | input | 1 | Fetch result present |
| walk_ppn | input | 20 | Physical page number returned by the fetch |

## Verification
A damaged replacement order does not show as a bad address. It shows as the wrong page being evicted, so the error surfaces only at a later miss that is several lookups away from the cause. The stimulus therefore fills all 16 entries and then mixes hits, misses and pass-through lookups in an order whose victims can be worked out by hand. Each eviction is confirmed by re-requesting both the evicted page and the page next in line. A stale valid bit after a flush, or a cancelled fetch that still writes, shows one cycle after the next lookup of that page as a hit where a miss is expected. A stuck fetch sequencer shows at once as `req_ready` staying low.

// File: rtl/aperture_remap_pkg.sv
package aperture_remap_pkg;
  localparam int ADDR_W      = 32;
  localparam int PAGE_OFFS_W = 12;
  localparam int VPN_W       = ADDR_W - PAGE_OFFS_W;
  localparam int PPN_W       = 20;
  localparam int PHYS_W      = PPN_W + PAGE_OFFS_W;
  localparam int N_CLASS     = 3;

  typedef enum logic [1:0] {
    CLS_HOST = 2'd0,
    CLS_GFX  = 2'd1,
    CLS_PCI  = 2'd2,
    CLS_RSVD = 2'd3
  } req_class_e;

  function automatic logic [VPN_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:PAGE_OFFS_W];
  endfunction

  function automatic logic [PHYS_W-1:0] join_page(input logic [PPN_W-1:0] p,
                                                  input logic [ADDR_W-1:0] a);
    return {p, a[PAGE_OFFS_W-1:0]};
  endfunction

  function automatic logic [PHYS_W-1:0] pass_addr(input logic [ADDR_W-1:0] a);
    return PHYS_W'(a);
  endfunction

  function automatic logic xlate_on(input logic [1:0] cls, input logic [N_CLASS-1:0] en);
    logic r;
    case (cls)
      CLS_HOST: r = en[0];
      CLS_GFX:  r = en[1];
      CLS_PCI:  r = en[2];
      default:  r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/arm_entry_array.sv
module arm_entry_array
  import aperture_remap_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PPN_W-1:0]   fill_ppn,
  output logic [ENTRIES-1:0] match_vec,
  output logic [ENTRIES-1:0] valid_vec,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx,
  output logic [PPN_W-1:0]   hit_ppn
);
  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i] <= '0;
        ppn_q[i] <= '0;
      end
    end else if (flush) begin
      valid_q <= '0;
    end else if (fill_en) begin
      valid_q[fill_idx] <= 1'b1;
      vpn_q[fill_idx]   <= fill_vpn;
      ppn_q[fill_idx]   <= fill_ppn;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid_q[g] && (vpn_q[g] == lk_vpn);
  end

  always_comb begin
    hit_idx = '0;
    hit_ppn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) begin
        hit_idx = hit_idx | IDX_W'(i);
        hit_ppn = hit_ppn | ppn_q[i];
      end
    end
  end

  assign hit       = |match_vec;
  assign valid_vec = valid_q;

  // R4: a page never lives in two entries
  a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
  // R4: a fill leaves its entry valid
  a_r4_fill_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en && !flush |=> valid_vec[$past(fill_idx)]);
  // R9: flush empties the array
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid_vec == '0);
endmodule

// File: rtl/arm_age_lru.sv
module arm_age_lru #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch_en,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic [ENTRIES-1:0] valid_vec,
  output logic [IDX_W-1:0]   victim_idx
);
  localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0]   age_q [ENTRIES];
  logic [IDX_W-1:0]   touched_age;
  logic [ENTRIES-1:0] oldest_vec;
  logic [ENTRIES-1:0] mru_vec;
  logic [IDX_W-1:0]   free_idx;
  logic [IDX_W-1:0]   old_idx;

  assign touched_age = age_q[touch_idx];

  // ages form a permutation; touching moves one entry to 0 and ages the younger ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx)     age_q[i] <= '0;
        else if (age_q[i] < touched_age) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_age
    assign oldest_vec[g] = (age_q[g] == AGE_MAX);
    assign mru_vec[g]    = (age_q[g] == '0);
  end

  always_comb begin
    free_idx = '0;
    old_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx = IDX_W'(i);
      if (oldest_vec[i]) old_idx  = IDX_W'(i);
    end
    victim_idx = (&valid_vec) ? old_idx : free_idx;
  end

  // R8: exactly one entry is the least recently used
  a_r8_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);
  // R8: a touched entry becomes most recently used
  a_r8_touch_mru: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> mru_vec[$past(touch_idx)]);
endmodule

// File: rtl/arm_walk_seq.sv
module arm_walk_seq
  import aperture_remap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VPN_W-1:0] start_vpn,
  input  logic             flush,
  input  logic             walk_ack,
  output logic             busy,
  output logic             walk_req,
  output logic [VPN_W-1:0] walk_vpn,
  output logic             fill_go
);
  logic             busy_q;
  logic             cancel_q;
  logic [VPN_W-1:0] vpn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cancel_q <= 1'b0;
      vpn_q    <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q   <= 1'b1;
        cancel_q <= 1'b0;
        vpn_q    <= start_vpn;
      end
    end else begin
      if (walk_ack) busy_q   <= 1'b0;
      if (flush)    cancel_q <= 1'b1;
    end
  end

  assign busy     = busy_q;
  assign walk_req = busy_q;
  assign walk_vpn = vpn_q;
  assign fill_go  = busy_q && walk_ack && !cancel_q && !flush;

  // R3: the request stays up until acknowledged
  a_r3_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req && !walk_ack |=> walk_req);
  // R3: the page number is steady while the request is up
  a_r3_vpn_stable: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req && $past(walk_req) |-> $stable(walk_vpn));
endmodule

// File: rtl/aperture_remap_tlb.sv
module aperture_remap_tlb
  import aperture_remap_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CLASS-1:0] xlate_en,
  input  logic               flush,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_class,
  input  logic [ADDR_W-1:0]  req_vaddr,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [PHYS_W-1:0]  rsp_paddr,
  output logic               walk_req,
  output logic [VPN_W-1:0]   walk_vpn,
  input  logic               walk_ack,
  input  logic [PPN_W-1:0]   walk_ppn
);
  logic               busy;
  logic               fill_go;
  logic               accept;
  logic               bypass;
  logic               lk_hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [PPN_W-1:0]   hit_ppn;
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] valid_vec;
  logic [IDX_W-1:0]   victim_idx;
  logic               miss_start;
  logic               touch_en;
  logic [IDX_W-1:0]   touch_idx;
  logic               rsp_valid_q;
  logic               rsp_hit_q;
  logic [PHYS_W-1:0]  rsp_paddr_q;

  assign req_ready  = !busy && !flush;
  assign accept     = req_valid && req_ready;
  assign bypass     = !xlate_on(req_class, xlate_en);
  assign miss_start = accept && !bypass && !lk_hit;
  assign touch_en   = (accept && !bypass && lk_hit) || fill_go;
  assign touch_idx  = fill_go ? victim_idx : hit_idx;

  arm_entry_array #(.ENTRIES(ENTRIES)) u_array (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_vpn(page_of(req_vaddr)),
    .fill_en(fill_go), .fill_idx(victim_idx),
    .fill_vpn(walk_vpn), .fill_ppn(walk_ppn),
    .match_vec(match_vec), .valid_vec(valid_vec),
    .hit(lk_hit), .hit_idx(hit_idx), .hit_ppn(hit_ppn)
  );

  arm_age_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .touch_en(touch_en), .touch_idx(touch_idx),
    .valid_vec(valid_vec), .victim_idx(victim_idx)
  );

  arm_walk_seq u_walk (
    .clk(clk), .rst_n(rst_n),
    .start(miss_start), .start_vpn(page_of(req_vaddr)),
    .flush(flush), .walk_ack(walk_ack),
    .busy(busy), .walk_req(walk_req), .walk_vpn(walk_vpn),
    .fill_go(fill_go)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_paddr_q <= '0;
    end else begin
      rsp_valid_q <= accept;
      if (accept) begin
        rsp_hit_q <= bypass || lk_hit;
        if (bypass)      rsp_paddr_q <= pass_addr(req_vaddr);
        else if (lk_hit) rsp_paddr_q <= join_page(hit_ppn, req_vaddr);
        else             rsp_paddr_q <= '0;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_paddr = rsp_paddr_q;

  // R2: every accepted lookup is answered next cycle
  a_r2_answer: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);
  // R5: no lookup accepted while a fetch is outstanding
  a_r5_stall: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> !req_ready);
  // R6: an untranslated lookup returns its own address
  a_r6_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !xlate_on(req_class, xlate_en)
    |=> rsp_hit && rsp_paddr == pass_addr($past(req_vaddr)) && !walk_req);
  // R3: a translated miss starts a fetch of its page
  a_r3_miss_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    miss_start |=> walk_req && !rsp_hit && walk_vpn == page_of($past(req_vaddr)));
endmodule

// File: tb/aperture_remap_tlb_tb_top.sv
module aperture_remap_tlb_tb_top;
  import aperture_remap_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        xlate_en = 3'b111;
  logic              flush = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [1:0]        req_class = 2'd0;
  logic [31:0]       req_vaddr = '0;
  logic              rsp_valid;
  logic              rsp_hit;
  logic [31:0]       rsp_paddr;
  logic              walk_req;
  logic [19:0]       walk_vpn;
  logic              walk_ack = 1'b0;
  logic [19:0]       walk_ppn = '0;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  aperture_remap_tlb dut_i (
    .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_class(req_class),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_paddr(rsp_paddr), .walk_req(walk_req), .walk_vpn(walk_vpn),
    .walk_ack(walk_ack), .walk_ppn(walk_ppn)
  );

  // table memory contents, independent of the design
  function automatic logic [19:0] ppn_of(input logic [19:0] v);
    return v ^ 20'h5A5A5;
  endfunction
  function automatic logic [11:0] offs_of(input int v);
    return 12'((v * 7 + 1) & 12'hFFF);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic lookup(input logic [1:0] cls, input int vpn, input bit exp_hit,
                        input bit exp_pass, input bit flush_mid, input string req);
    logic [31:0] va;
    logic [31:0] pa;
    va = {vpn[19:0], offs_of(vpn)};
    @(negedge clk);
    req_valid = 1'b1; req_class = cls; req_vaddr = va;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, req, "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(rsp_hit == exp_hit, req, "rsp_hit", 32'(rsp_hit), 32'(exp_hit));
    if (exp_hit) begin
      pa = exp_pass ? va : {ppn_of(vpn[19:0]), va[11:0]};
      chk(rsp_paddr == pa, req, "rsp_paddr", rsp_paddr, pa);
      chk(walk_req == 1'b0, req, "no fetch on hit", 32'(walk_req), 32'd0);
    end else begin
      chk(walk_req && walk_vpn == vpn[19:0], "R3", "walk_vpn", 32'(walk_vpn), 32'(vpn));
      chk(!req_ready, "R5", "ready during fetch", 32'(req_ready), 32'd0);
      repeat (2) @(negedge clk);
      chk(!req_ready && walk_req, "R5", "stall held", 32'(req_ready), 32'd0);
      if (flush_mid) begin
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
      end
      walk_ack = 1'b1;
      walk_ppn = ppn_of(walk_vpn);
      @(negedge clk);
      walk_ack = 1'b0;
      chk(req_ready && !walk_req, "R5", "ready after ack", 32'(req_ready), 32'd1);
    end
  endtask

  // {class, page, expected hit}; pages are 0x100+n
  localparam int NV = 14;
  localparam logic [22:0] VEC [NV] = '{
    {2'd0, 20'h103, 1'b1},
    {2'd0, 20'h100, 1'b1},
    {2'd0, 20'h110, 1'b0},
    {2'd0, 20'h110, 1'b1},
    {2'd0, 20'h101, 1'b0},
    {2'd0, 20'h101, 1'b1},
    {2'd0, 20'h100, 1'b1},
    {2'd1, 20'h102, 1'b0},
    {2'd2, 20'h102, 1'b1},
    {2'd0, 20'h104, 1'b0},
    {2'd0, 20'h104, 1'b1},
    {2'd0, 20'h105, 1'b0},
    {2'd0, 20'h106, 1'b0},
    {2'd0, 20'h108, 1'b1}
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready", 32'(req_ready), 32'd1);
    chk(walk_req == 1'b0, "R1", "walk_req", 32'(walk_req), 32'd0);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", 32'(rsp_valid), 32'd0);

    // R1/R2/R4: fill all entries, each miss followed by a hit
    for (int i = 0; i < 16; i++) begin
      lookup(2'd0, 32'h100 + i, 1'b0, 1'b0, 1'b0, "R1");
      lookup(2'd0, 32'h100 + i, 1'b1, 1'b0, 1'b0, "R2");
    end
    // R11: all sixteen resident together (touching in order keeps the age order)
    for (int i = 0; i < 16; i++) lookup(2'd0, 32'h100 + i, 1'b1, 1'b0, 1'b0, "R11");

    // R8: replacement order vectors
    for (int k = 0; k < NV; k++)
      lookup(VEC[k][22:21], int'(VEC[k][20:1]), VEC[k][0], 1'b0, 1'b0, "R8");

    // R4: an entry filled for the host hits for PCI
    lookup(2'd2, 32'h110, 1'b1, 1'b0, 1'b0, "R4");

    // R6: graphics class disabled, absent page passes through without a fetch
    xlate_en = 3'b101;
    lookup(2'd1, 32'h107, 1'b1, 1'b1, 1'b0, "R6");
    // R7: pass-through of the oldest resident page does not refresh it
    lookup(2'd1, 32'h109, 1'b1, 1'b1, 1'b0, "R7");
    xlate_en = 3'b111;
    lookup(2'd0, 32'h114, 1'b0, 1'b0, 1'b0, "R7");
    lookup(2'd0, 32'h109, 1'b0, 1'b0, 1'b0, "R7");
    lookup(2'd0, 32'h10B, 1'b1, 1'b0, 1'b0, "R8");
    // R6: code 3 is never translated
    lookup(2'd3, 32'h10B, 1'b1, 1'b1, 1'b0, "R6");

    // R9: flush
    @(negedge clk);
    flush = 1'b1;
    #1 chk(req_ready == 1'b0, "R9", "ready during flush", 32'(req_ready), 32'd0);
    @(negedge clk);
    flush = 1'b0;
    lookup(2'd0, 32'h10B, 1'b0, 1'b0, 1'b0, "R9");
    lookup(2'd0, 32'h10B, 1'b1, 1'b0, 1'b0, "R9");

    // R10: flush while a fetch is outstanding discards the fill
    lookup(2'd0, 32'h130, 1'b0, 1'b0, 1'b1, "R10");
    lookup(2'd0, 32'h130, 1'b0, 1'b0, 1'b0, "R10");
    lookup(2'd0, 32'h130, 1'b1, 1'b0, 1'b0, "R10");

    // R6: PCI disabled alone
    xlate_en = 3'b011;
    lookup(2'd2, 32'h130, 1'b1, 1'b1, 1'b0, "R6");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule